// File: doc/BRIEF.md
# Power-On Safe Startup Sequencer

This block runs the startup of a high-voltage control board as soon as power is applied, with no software involved. It first holds every DAC setpoint at zero through a clear strobe. Once the strobe drops it closes all over-current protection relays together. It then waits through a long blanking window, nominally one second, so that inrush and other transient currents at power-up cannot be taken for a fault. When the window ends it arms the hardware current monitor on its own and raises a ready flag.

When the monitor is armed, the block watches a vector of current-comparator trip inputs. Each input has a mask bit. Any trip input that is not masked sets a latched protection-trip output, and only a reset clears it. A synchronous active-high reset can arrive at any point. It returns the sequence to its starting state, opens the relays and disarms the monitor.

The number of DAC channels, relays and trip inputs is set by parameters, and so are the lengths of the clear strobe and of the blanking window in clock cycles. The blanking length can be made small for simulation.

Top module: `hv_startup_seq`

## Requirements
- R1: While `rst` is high, every `dac_clear` bit is 1 and every `relay_en` bit is 0, and `monitor_en`, `ready` and `protect_trip` are 0.
- R2: After `rst` falls, `dac_clear` stays high for the first edge plus CLEAR_CYCLES more cycles, then drops. Throughout that time all relays stay off.
- R3: All `relay_en` bits rise together in the cycle in which `dac_clear` drops. `dac_clear` and `relay_en` are never high together. Relays stay on until a reset.
- R4: `monitor_en` rises after exactly BLANK_CYCLES+1 cycles in which the relays are on and the monitor is off. Once high it stays high until a reset.
- R5: `ready` is high exactly when `monitor_en` is high.
- R6: Trip inputs have no effect before the monitor is armed. `protect_trip` stays 0 all through the clear, relay and blanking phases, even with trips held high.
- R7: While armed, a trip input whose `trip_mask` bit is 0 sets `protect_trip` one clock later. A trip input whose mask bit is 1 is ignored.
- R8: Once set, `protect_trip` stays at 1 after the trip inputs return to 0, until a reset.
- R9: A reset in any phase, including the armed and tripped states, brings the outputs back to the R1 values one clock later. It restarts the whole sequence when released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| trip_in | input | NUM_TRIP | Current-comparator trip inputs, active high |
| trip_mask | input | NUM_TRIP | Per-input mask, 1 suppresses that trip input |
| dac_clear | output | NUM_DAC | Force-to-zero strobe for each DAC setpoint |
| relay_en | output | NUM_RELAY | Over-current protection relay enables |
| monitor_en | output | 1 | Hardware current monitor armed |
| ready | output | 1 | Startup sequence complete |
| protect_trip | output | 1 | Latched protection trip |

## Verification
Two events can fall in the same cycle: the end of blanking, where the monitor arms, and a trip input that is already high. The bench holds every combination of trip input and mask high from reset release through arming. It expects `protect_trip` to stay 0 through the last blanking cycle and to rise exactly one edge after `monitor_en`, and only when a trip input is not masked. A second pairing, reset arriving in the blanking phase or in an already tripped armed state, is judged by the outputs in the cycle that follows.

// File: rtl/hv_seq_pkg.sv
package hv_seq_pkg;

    typedef enum logic [2:0] {
        SEQ_RESET = 3'd0,
        SEQ_CLEAR = 3'd1,
        SEQ_RELAY = 3'd2,
        SEQ_BLANK = 3'd3,
        SEQ_ARMED = 3'd4
    } seq_state_e;

    typedef struct packed {
        logic dac_clear;
        logic relay_on;
        logic monitor_on;
        logic ready;
    } seq_ctrl_t;

    // Bits needed to hold a count from 0 to n-1.
    function automatic int unsigned cnt_width(input int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    // Output controls implied by each phase.
    function automatic seq_ctrl_t decode_ctrl(input seq_state_e s);
        seq_ctrl_t c;
        c = '0;
        unique case (s)
            SEQ_RESET: c.dac_clear  = 1'b1;
            SEQ_CLEAR: c.dac_clear  = 1'b1;
            SEQ_RELAY: c.relay_on   = 1'b1;
            SEQ_BLANK: c.relay_on   = 1'b1;
            SEQ_ARMED: begin
                c.relay_on   = 1'b1;
                c.monitor_on = 1'b1;
                c.ready      = 1'b1;
            end
            default:   c.dac_clear  = 1'b1;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/hv_seq_timer.sv
module hv_seq_timer #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [WIDTH-1:0] load_val,
    output logic             done
);

    logic [WIDTH-1:0] count_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            count_q <= '0;
        end else if (load) begin
            count_q <= load_val;
        end else if (count_q != '0) begin
            count_q <= count_q - 1'b1;
        end
    end

    assign done = (count_q == '0);

endmodule

// File: rtl/hv_seq_fsm.sv
module hv_seq_fsm
    import hv_seq_pkg::*;
#(
    parameter int unsigned CLEAR_CYCLES = 4,
    parameter int unsigned BLANK_CYCLES = 16,
    parameter int unsigned TW           = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          timer_done,
    output logic          timer_load,
    output logic [TW-1:0] timer_val,
    output seq_state_e    state
);

    localparam logic [TW-1:0] CLEAR_LOAD = TW'(CLEAR_CYCLES - 1);
    localparam logic [TW-1:0] BLANK_LOAD = TW'(BLANK_CYCLES - 1);

    seq_state_e state_q, state_d;

    always_comb begin
        state_d    = state_q;
        timer_load = 1'b0;
        timer_val  = '0;
        unique case (state_q)
            SEQ_RESET: begin
                state_d    = SEQ_CLEAR;
                timer_load = 1'b1;
                timer_val  = CLEAR_LOAD;
            end
            SEQ_CLEAR: begin
                if (timer_done) begin
                    state_d = SEQ_RELAY;
                end
            end
            SEQ_RELAY: begin
                state_d    = SEQ_BLANK;
                timer_load = 1'b1;
                timer_val  = BLANK_LOAD;
            end
            SEQ_BLANK: begin
                if (timer_done) begin
                    state_d = SEQ_ARMED;
                end
            end
            SEQ_ARMED: state_d = SEQ_ARMED;
            default:   state_d = SEQ_RESET;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_RESET;
        end else begin
            state_q <= state_d;
        end
    end

    assign state = state_q;

endmodule

// File: rtl/hv_trip_latch.sv
module hv_trip_latch #(
    parameter int unsigned NUM_TRIP = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                arm,
    input  logic [NUM_TRIP-1:0] trip_in,
    input  logic [NUM_TRIP-1:0] trip_mask,
    output logic                trip_out
);

    logic [NUM_TRIP-1:0] live;
    logic                trip_q;

    assign live = trip_in & ~trip_mask;

    always_ff @(posedge clk) begin
        if (rst) begin
            trip_q <= 1'b0;
        end else if (arm && (live != '0)) begin
            trip_q <= 1'b1;
        end
    end

    assign trip_out = trip_q;

endmodule

// File: rtl/hv_startup_seq.sv
module hv_startup_seq
    import hv_seq_pkg::*;
#(
    parameter int unsigned NUM_DAC      = 8,
    parameter int unsigned NUM_RELAY    = 2,
    parameter int unsigned NUM_TRIP     = 6,
    parameter int unsigned CLEAR_CYCLES = 16,
    parameter int unsigned BLANK_CYCLES = 250_000_000
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_TRIP-1:0]  trip_in,
    input  logic [NUM_TRIP-1:0]  trip_mask,
    output logic [NUM_DAC-1:0]   dac_clear,
    output logic [NUM_RELAY-1:0] relay_en,
    output logic                 monitor_en,
    output logic                 ready,
    output logic                 protect_trip
);

    localparam int unsigned TW = cnt_width(max_u(CLEAR_CYCLES, BLANK_CYCLES));

    seq_state_e    state;
    seq_ctrl_t     ctrl;
    logic          timer_load;
    logic [TW-1:0] timer_val;
    logic          timer_done;

    hv_seq_fsm #(
        .CLEAR_CYCLES (CLEAR_CYCLES),
        .BLANK_CYCLES (BLANK_CYCLES),
        .TW           (TW)
    ) i_fsm (
        .clk        (clk),
        .rst        (rst),
        .timer_done (timer_done),
        .timer_load (timer_load),
        .timer_val  (timer_val),
        .state      (state)
    );

    hv_seq_timer #(
        .WIDTH (TW)
    ) i_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (timer_load),
        .load_val (timer_val),
        .done     (timer_done)
    );

    assign ctrl = decode_ctrl(state);

    generate
        for (genvar d = 0; d < NUM_DAC; d++) begin : g_dac
            assign dac_clear[d] = ctrl.dac_clear;
        end
        for (genvar r = 0; r < NUM_RELAY; r++) begin : g_relay
            assign relay_en[r] = ctrl.relay_on;
        end
    endgenerate

    assign monitor_en = ctrl.monitor_on;
    assign ready      = ctrl.ready;

    hv_trip_latch #(
        .NUM_TRIP (NUM_TRIP)
    ) i_trip (
        .clk       (clk),
        .rst       (rst),
        .arm       (ctrl.monitor_on),
        .trip_in   (trip_in),
        .trip_mask (trip_mask),
        .trip_out  (protect_trip)
    );

endmodule

// File: rtl/hv_startup_seq_chk.sv
module hv_startup_seq_chk #(
    parameter int unsigned NUM_DAC      = 8,
    parameter int unsigned NUM_RELAY    = 2,
    parameter int unsigned NUM_TRIP     = 6,
    parameter int unsigned CLEAR_CYCLES = 16,
    parameter int unsigned BLANK_CYCLES = 16
) (
    input logic                 clk,
    input logic                 rst,
    input logic [NUM_DAC-1:0]   dac_clear,
    input logic [NUM_RELAY-1:0] relay_en,
    input logic                 monitor_en,
    input logic                 ready,
    input logic                 protect_trip
);

    int unsigned clr_cnt;
    int unsigned blank_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            clr_cnt   <= 0;
            blank_cnt <= 0;
        end else begin
            if (dac_clear[0]) clr_cnt <= clr_cnt + 1;
            if (relay_en[0] && !monitor_en) blank_cnt <= blank_cnt + 1;
        end
    end

    // R2
    clear_len_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(dac_clear[0]) |-> (clr_cnt == CLEAR_CYCLES + 1));

    // R3
    no_overlap_chk: assert property (@(posedge clk) disable iff (rst)
        (dac_clear != '0) |-> (relay_en == '0));

    // R3
    relay_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (relay_en != '0) |=> (relay_en == '1));

    // R4
    blank_len_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(monitor_en) |-> (blank_cnt == BLANK_CYCLES + 1));

    // R5
    ready_match_chk: assert property (@(posedge clk) disable iff (rst)
        ready == monitor_en);

    // R6
    trip_needs_arm_chk: assert property (@(posedge clk) disable iff (rst)
        protect_trip |-> monitor_en);

    // R7
    trip_after_arm_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(protect_trip) |-> $past(monitor_en));

    // R8
    trip_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        protect_trip |=> protect_trip);

    // R9
    reset_exit_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (relay_en == '0 && !monitor_en && !protect_trip && dac_clear == '1));

endmodule

bind hv_startup_seq hv_startup_seq_chk #(
    .NUM_DAC      (NUM_DAC),
    .NUM_RELAY    (NUM_RELAY),
    .NUM_TRIP     (NUM_TRIP),
    .CLEAR_CYCLES (CLEAR_CYCLES),
    .BLANK_CYCLES (BLANK_CYCLES)
) i_chk (
    .clk          (clk),
    .rst          (rst),
    .dac_clear    (dac_clear),
    .relay_en     (relay_en),
    .monitor_en   (monitor_en),
    .ready        (ready),
    .protect_trip (protect_trip)
);

// File: tb/test_hv_startup_seq.sv
module test_hv_startup_seq;

    localparam int unsigned ND = 3;
    localparam int unsigned NR = 2;
    localparam int unsigned NT = 4;
    localparam int unsigned CC = 3;
    localparam int unsigned BC = 12;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NT-1:0] trip_in = '0;
    logic [NT-1:0] trip_mask = '0;
    logic [ND-1:0] dac_clear;
    logic [NR-1:0] relay_en;
    logic          monitor_en;
    logic          ready;
    logic          protect_trip;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    hv_startup_seq #(
        .NUM_DAC      (ND),
        .NUM_RELAY    (NR),
        .NUM_TRIP     (NT),
        .CLEAR_CYCLES (CC),
        .BLANK_CYCLES (BC)
    ) i_hv_startup_seq (
        .clk          (clk),
        .rst          (rst),
        .trip_in      (trip_in),
        .trip_mask    (trip_mask),
        .dac_clear    (dac_clear),
        .relay_en     (relay_en),
        .monitor_en   (monitor_en),
        .ready        (ready),
        .protect_trip (protect_trip)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic chk_outputs(input string req, input bit clr, input bit rel,
                               input bit mon, input bit trp);
        chk(req, "dac_clear",    32'(dac_clear),    clr ? 32'((1 << ND) - 1) : 32'd0);
        chk(req, "relay_en",     32'(relay_en),     rel ? 32'((1 << NR) - 1) : 32'd0);
        chk(req, "monitor_en",   32'(monitor_en),   32'(mon));
        chk(req, "ready",        32'(ready),        32'(mon));
        chk(req, "protect_trip", 32'(protect_trip), 32'(trp));
    endtask

    // Reset, then release and follow every cycle of the startup with trips held.
    task automatic run_seq(input logic [NT-1:0] mask, input logic [NT-1:0] trips,
                           input int stop_k);
        bit hit;
        hit = ((trips & ~mask) != '0);
        @(negedge clk);
        rst       = 1'b1;
        trip_mask = mask;
        trip_in   = trips;
        repeat (2) @(negedge clk);
        chk_outputs("R1", 1'b1, 1'b0, 1'b0, 1'b0);
        rst = 1'b0;
        for (int k = 0; k <= stop_k; k++) begin
            @(negedge clk);
            if (k < CC)
                chk_outputs("R2", 1'b1, 1'b0, 1'b0, 1'b0);
            else if (k == CC)
                chk_outputs("R3", 1'b0, 1'b1, 1'b0, 1'b0);
            else if (k <= CC + BC)
                chk_outputs("R6", 1'b0, 1'b1, 1'b0, 1'b0);
            else if (k == CC + BC + 1)
                chk_outputs("R4", 1'b0, 1'b1, 1'b1, 1'b0);
            else
                chk_outputs("R7", 1'b0, 1'b1, 1'b1, hit);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        // R6 R7: every trip/mask combination held from release through arming.
        for (int m = 0; m < (1 << NT); m++) begin
            for (int t = 0; t < (1 << NT); t++) begin
                run_seq(NT'(m), NT'(t), CC + BC + 4);
                // R8: trip stays latched after the inputs drop.
                trip_in = '0;
                repeat (3) @(negedge clk);
                chk("R8", "protect_trip held",
                    32'(protect_trip), 32'((NT'(t) & ~NT'(m)) != '0));
            end
        end

        // R7: trip raised only after arming, single unmasked bit.
        run_seq('0, '0, CC + BC + 3);
        chk("R7", "no trip armed idle", 32'(protect_trip), 32'd0);
        trip_mask = 4'b1101;
        trip_in   = 4'b0010;
        @(negedge clk);
        chk("R7", "late unmasked trip", 32'(protect_trip), 32'd1);

        // R9: reset from tripped armed state.
        rst = 1'b1;
        trip_in = '0;
        @(negedge clk);
        chk_outputs("R9", 1'b1, 1'b0, 1'b0, 1'b0);

        // R9: reset in mid blanking, then a full restart.
        run_seq('0, 4'b0001, CC + 4);
        rst = 1'b1;
        @(negedge clk);
        chk_outputs("R9", 1'b1, 1'b0, 1'b0, 1'b0);
        run_seq('0, 4'b0001, CC + BC + 3);

        $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule